// File: doc/BRIEF.md
# Serial ADC capture controller

This block sits on the host side of a serial-output successive-approximation converter. It produces the converter's clock from the system clock, drives the converter's active-low start-convert line and reads the single data pin. It assembles each 10-bit result MSB first and presents it with a one-cycle valid strobe. A converter frame lasts 14 converter clocks. The first three clocks are used for calibration and sampling. The ten data bits follow, one per clock, each changing shortly after a falling edge of the converter clock.

The converter clock runs at a programmable half-period of `half_i` system cycles, so the duty cycle is always exactly 50%. The clock is only running while a frame is in progress. Three modes are supported. In single-shot mode one frame runs per start request. In free-run mode start-convert stays low and frames follow each other directly. In synchronous mode start-convert is pulsed inside every frame and frames still follow each other directly.

Every bit is captured on the system edge at which the converter clock rises, which is the last system cycle of the low phase that follows the bit change. The LSB is only valid during that low phase, and this capture point also falls inside it.

Top module: `sadc_capture_ctrl`

## Requirements
- R1: While reset is active and right after it, `adc_clk_o` is 0, `adc_sc_no` is 1, `valid_o` is 0 and `data_o` is 0.
- R2: During a frame, each high phase and each low phase of `adc_clk_o` lasts exactly `half_i` system cycles. The value is latched at the start from idle, and a value of 0 is treated as 1.
- R3: A `start_i` pulse while idle produces exactly 14 rising edges of `adc_clk_o` for a single-shot frame, and exactly one result.
- R4: `adc_sc_no` goes low in the cycle after the accepted `start_i`, before the first rising edge. In single-shot and synchronous frames it returns high at the falling edge of converter clock 1. It only ever changes while `adc_clk_o` is low.
- R5: Free-run mode (`mode_i`=1) keeps `adc_sc_no` low across frames. Consecutive results are 28·`half_i` system cycles apart.
- R6: Synchronous mode (`mode_i`=2) drives `adc_sc_no` high at the fall of clock 1 and low again at the fall of clock 13. This gives one start-convert pulse per frame, and results 28·`half_i` cycles apart.
- R7: `adc_sdo_i` is sampled at the system edge where `adc_clk_o` rises for converter clocks 5 to 14. The bits are shifted in MSB first, so `data_o[9]` is the bit present after the fall of clock 4. The LSB is taken correctly even though it changes again right after the rise of clock 14.
- R8: `valid_o` is high for exactly one cycle, in the cycle after the LSB capture. `data_o` changes only together with `valid_o` and otherwise holds the last result.
- R9: The value of `mode_i` at the fall of clock 13 decides what follows. Value 1 or 2 starts the next frame back to back; value 0 or 3 ends the run after clock 14.
- R10: `start_i` and changes of `half_i` have no effect while a run is in progress.
- R11: When no run is active, `adc_clk_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a run (accepted only when idle) |
| mode_i | input | 2 | 0 single-shot, 1 free-run, 2 synchronous, 3 as 0 |
| half_i | input | DIV_W | Converter clock half-period in system cycles |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_clk_o | output | 1 | Converter clock |
| adc_sc_no | output | 1 | Start-convert, active low |
| data_o | output | DATA_W | Last captured result |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
Some rules are checked by the assertions on every cycle:
- the converter clock stays low whenever the controller is idle;
- start-convert never moves while the converter clock is high;
- the valid strobe lasts exactly one cycle, and the result register only changes with it;
- the frame counter stays in range.

Other properties can only be shown by the bench's scenarios, which run against a behavioural converter model:
- the exact half-period;
- capture of the correct bit for each slot, including the short LSB;
- the back-to-back spacing in free-run and synchronous modes;
- the number of start-convert pulses;
- the end-of-run decision taken at clock 13;
- ignoring of a second start.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_RSVD   = 2'd3
  } sadc_mode_e;

  function automatic logic mode_repeats(sadc_mode_e m);
    return (m == MODE_FREE) || (m == MODE_SYNC);
  endfunction
endpackage

// File: rtl/sadc_clk_div.sv
`timescale 1ns/1ps
module sadc_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             conv_clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             tick;

  assign tick       = run_i && (cnt_q == half_i - DIV_W'(1));
  assign rise_o     = tick && !clk_q;
  assign fall_o     = tick && clk_q;
  assign conv_clk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      if (!hold_i) clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/sadc_frame_seq.sv
`timescale 1ns/1ps
module sadc_frame_seq
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int LEAD_CLKS = 3,
  parameter int DIV_W     = 8,
  localparam int FRAME_CLKS = LEAD_CLKS + DATA_W + 1,
  localparam int IDX_W      = $clog2(FRAME_CLKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  sadc_mode_e       mode_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             run_o,
  output logic             hold_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             sc_no,
  output logic [DIV_W-1:0] half_o,
  output logic             sample_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] IDX_FRAME = IDX_W'(FRAME_CLKS);
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(LEAD_CLKS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(LEAD_CLKS + DATA_W);
  localparam logic [IDX_W-1:0] IDX_DECIDE = IDX_W'(FRAME_CLKS - 1);

  logic             run_q, sc_q, cont_q;
  logic [IDX_W-1:0] idx_q;
  logic [DIV_W-1:0] half_q;
  sadc_mode_e       frame_mode_q, next_mode_q;
  logic             rise_act;

  // stop instead of starting clock 15 when no follow-up frame
  assign hold_o   = rise_i && (idx_q == IDX_FRAME) && !cont_q;
  assign rise_act = rise_i && !hold_o;
  assign sample_o = rise_act && (idx_q >= IDX_FIRST) && (idx_q <= IDX_LAST);
  assign last_o   = rise_act && (idx_q == IDX_LAST);
  assign run_o    = run_q;
  assign idx_o    = idx_q;
  assign sc_no    = sc_q;
  assign half_o   = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= 1'b0;
      sc_q         <= 1'b1;
      cont_q       <= 1'b0;
      idx_q        <= '0;
      half_q       <= DIV_W'(1);
      frame_mode_q <= MODE_SINGLE;
      next_mode_q  <= MODE_SINGLE;
    end else if (!run_q) begin
      if (start_i) begin
        run_q        <= 1'b1;
        sc_q         <= 1'b0;
        cont_q       <= 1'b0;
        idx_q        <= '0;
        frame_mode_q <= mode_i;
        half_q       <= (half_i == '0) ? DIV_W'(1) : half_i;
      end
    end else begin
      if (hold_o) begin
        run_q <= 1'b0;
        idx_q <= '0;
      end else if (rise_i) begin
        if (idx_q == IDX_FRAME) begin
          idx_q        <= IDX_W'(1);
          frame_mode_q <= next_mode_q;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
      if (fall_i && idx_q == IDX_W'(1)) sc_q <= (frame_mode_q != MODE_FREE);
      if (fall_i && idx_q == IDX_DECIDE) begin
        cont_q      <= mode_repeats(mode_i);
        next_mode_q <= mode_i;
        sc_q        <= !mode_repeats(mode_i);
      end
    end
  end
endmodule

// File: rtl/sadc_shift_cap.sv
`timescale 1ns/1ps
module sadc_shift_cap #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] sh_q, data_q, sh_nxt;
  logic              valid_q;

  assign sh_nxt  = {sh_q[DATA_W-2:0], sdo_i};
  assign data_o  = data_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last_i;
      if (sample_i) sh_q <= sh_nxt;
      if (last_i) data_q <= sh_nxt;
    end
  end
endmodule

// File: rtl/sadc_capture_ctrl.sv
`timescale 1ns/1ps
module sadc_capture_ctrl
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int LEAD_CLKS = 3,
  parameter int DIV_W     = 8,
  localparam int FRAME_CLKS = LEAD_CLKS + DATA_W + 1,
  localparam int IDX_W      = $clog2(FRAME_CLKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              adc_sdo_i,
  output logic              adc_clk_o,
  output logic              adc_sc_no,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic             run_q, hold, rise, fall, sample, last;
  logic [IDX_W-1:0] idx_q;
  logic [DIV_W-1:0] half_eff;

  sadc_frame_seq #(
    .DATA_W(DATA_W), .LEAD_CLKS(LEAD_CLKS), .DIV_W(DIV_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (sadc_mode_e'(mode_i)),
    .half_i  (half_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .run_o   (run_q),
    .hold_o  (hold),
    .idx_o   (idx_q),
    .sc_no   (adc_sc_no),
    .half_o  (half_eff),
    .sample_o(sample),
    .last_o  (last)
  );

  sadc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .hold_i    (hold),
    .half_i    (half_eff),
    .conv_clk_o(adc_clk_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  sadc_shift_cap #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample),
    .last_i  (last),
    .sdo_i   (adc_sdo_i),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/sadc_capture_chk.sv
`timescale 1ns/1ps
module sadc_capture_chk #(
  parameter int DATA_W = 10,
  parameter int IDX_W  = 4,
  parameter int FRAME_CLKS = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_clk_o,
  input logic              adc_sc_no,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              run_q,
  input logic [IDX_W-1:0]  idx_q
);
  assert_idle_clk_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !adc_clk_o);

  assert_clk_moves_in_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(adc_clk_o) |-> $past(run_q));

  assert_sc_moves_clk_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(adc_sc_no) |-> !adc_clk_o);

  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_data_with_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> valid_o);

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_clk_o |-> (idx_q >= IDX_W'(1)) && (idx_q <= IDX_W'(FRAME_CLKS)));
endmodule

bind sadc_capture_ctrl sadc_capture_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .FRAME_CLKS(FRAME_CLKS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .adc_clk_o(adc_clk_o),
  .adc_sc_no(adc_sc_no),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .run_q    (run_q),
  .idx_q    (idx_q)
);

// File: tb/sim_sadc_capture_ctrl.sv
`timescale 1ns/1ps
module sim_sadc_capture_ctrl;
  localparam int PER = 10;
  localparam int DW  = 10;
  localparam int FR  = 14;
  localparam int NV  = 6;
  // {half[7:0], word[9:0]}
  localparam logic [17:0] VEC [NV] = '{
    {8'd1, 10'h3FF}, {8'd1, 10'h000}, {8'd2, 10'h2A5},
    {8'd3, 10'h155}, {8'd4, 10'h200}, {8'd7, 10'h001}
  };

  logic          clk = 0, rst_ni = 0, start_i = 0, sdo = 0;
  logic [1:0]    mode_i = 0;
  logic [7:0]    half_i = 8'd1;
  logic          adc_clk_o, adc_sc_no, valid_o;
  logic [DW-1:0] data_o;

  int checks = 0, errors = 0, cyc = 0;

  sadc_capture_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .half_i(half_i), .adc_sdo_i(sdo), .adc_clk_o(adc_clk_o),
    .adc_sc_no(adc_sc_no), .data_o(data_o), .valid_o(valid_o)
  );

  always #(PER/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // converter model
  logic [DW-1:0] words [8];
  logic [DW-1:0] cur = '0;
  int wp = 0, m_idx = 0, n_rise = 0, duty_bad = 0, exp_half = 1;
  longint t_rise = 0, t_fall = 0;
  bit have_fall = 0;

  always @(posedge adc_clk_o) begin
    n_rise++;
    if (have_fall && ($time - t_fall) != longint'(exp_half * PER)) duty_bad++;
    t_rise = $time;
    if (m_idx == 0 || m_idx == FR) begin
      if (!adc_sc_no) begin
        m_idx = 1;
        cur = (wp < 8) ? words[wp] : '0;
        wp++;
      end else m_idx = 0;
    end else begin
      m_idx++;
      if (m_idx == FR) begin
        #1 sdo = ~cur[0];
      end
    end
  end

  always @(negedge adc_clk_o) begin
    if (($time - t_rise) != longint'(exp_half * PER)) duty_bad++;
    t_fall = $time;
    have_fall = 1;
    if (m_idx >= 4 && m_idx <= 3 + DW) begin
      #3 sdo = cur[DW + 3 - m_idx];
    end
  end

  // output monitor
  logic [DW-1:0] caps [16];
  int cap_cyc [16];
  int ncap = 0, sc_rises = 0, valid_wide = 0;
  logic valid_prev = 0, sc_prev = 1;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o && ncap < 16) begin
        caps[ncap] = data_o;
        cap_cyc[ncap] = cyc;
        ncap++;
      end
      if (valid_o && valid_prev) valid_wide++;
      if (adc_sc_no && !sc_prev) sc_rises++;
    end
    valid_prev = valid_o;
    sc_prev = adc_sc_no;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic prep(input int h);
    wp = 0; n_rise = 0; duty_bad = 0; sc_rises = 0; valid_wide = 0;
    exp_half = h; have_fall = 0; half_i = 8'(h);
  endtask

  task automatic idle_check(input string req, input int h);
    int r0;
    r0 = n_rise;
    wait_cyc(4 * h + 8);
    check(n_rise == r0 && adc_clk_o == 1'b0, req, n_rise, r0);
  endtask

  task automatic wait_caps(input int target);
    for (int g = 0; g < 5000 && ncap < target; g++) @(negedge clk);
  endtask

  initial begin
    #(PER * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, h;
    // R1: reset state
    wait_cyc(3);
    check(adc_clk_o == 0 && adc_sc_no == 1 && valid_o == 0 && data_o == 0,
          "R1", {adc_clk_o, adc_sc_no, valid_o}, 3'b010);
    @(negedge clk) rst_ni = 1;
    wait_cyc(2);
    check(adc_clk_o == 0 && adc_sc_no == 1, "R1", {adc_clk_o, adc_sc_no}, 2'b01);

    // table: single-shot frames
    for (int v = 0; v < NV; v++) begin
      h = int'(VEC[v][17:10]);
      prep(h);
      words[0] = VEC[v][9:0];
      mode_i = (v == NV - 1) ? 2'd3 : 2'd0;
      base = ncap;
      pulse_start();
      wait_cyc(30 * h + 10);
      check(ncap == base + 1, "R3", ncap - base, 1);
      check(caps[base] == VEC[v][9:0], "R7", caps[base], VEC[v][9:0]);
      check(n_rise == FR, "R3", n_rise, FR);
      check(duty_bad == 0, "R2", duty_bad, 0);
      check(sc_rises == 1 && adc_sc_no == 1, "R4", sc_rises, 1);
      check(valid_wide == 0 && data_o == VEC[v][9:0], "R8", data_o, VEC[v][9:0]);
      idle_check("R11", h);
    end

    // R10: second start and half change during a run are ignored
    prep(3);
    words[0] = 10'h0F0;
    mode_i = 2'd0;
    base = ncap;
    pulse_start();
    wait_cyc(20);
    half_i = 8'd1;
    pulse_start();
    wait_cyc(30 * 3 + 20);
    check(n_rise == FR && ncap == base + 1, "R10", n_rise, FR);
    check(duty_bad == 0, "R10", duty_bad, 0);
    check(caps[base] == 10'h0F0, "R7", caps[base], 10'h0F0);

    // R5/R9: free-run, then fall back to single-shot
    prep(2);
    words[0] = 10'h111; words[1] = 10'h222; words[2] = 10'h333; words[3] = 10'h3C3;
    mode_i = 2'd1;
    base = ncap;
    pulse_start();
    wait_caps(base + 3);
    mode_i = 2'd0;
    wait_cyc(30 * 2 + 20);
    check(ncap == base + 4 && n_rise == 4 * FR, "R9", n_rise, 4 * FR);
    for (int k = 0; k < 4; k++)
      check(caps[base + k] == words[k], "R7", caps[base + k], words[k]);
    for (int k = 0; k < 3; k++)
      check(cap_cyc[base + k + 1] - cap_cyc[base + k] == 2 * FR * 2, "R5",
            cap_cyc[base + k + 1] - cap_cyc[base + k], 2 * FR * 2);
    check(sc_rises == 1, "R5", sc_rises, 1);
    check(duty_bad == 0, "R2", duty_bad, 0);
    idle_check("R11", 2);

    // R6/R9: synchronous, then stop
    prep(1);
    words[0] = 10'h00F; words[1] = 10'h3F0; words[2] = 10'h2AA; words[3] = 10'h155;
    mode_i = 2'd2;
    base = ncap;
    pulse_start();
    wait_caps(base + 3);
    mode_i = 2'd0;
    wait_cyc(30 + 20);
    check(ncap == base + 4 && n_rise == 4 * FR, "R9", n_rise, 4 * FR);
    for (int k = 0; k < 4; k++)
      check(caps[base + k] == words[k], "R7", caps[base + k], words[k]);
    for (int k = 0; k < 3; k++)
      check(cap_cyc[base + k + 1] - cap_cyc[base + k] == 2 * FR, "R6",
            cap_cyc[base + k + 1] - cap_cyc[base + k], 2 * FR);
    check(sc_rises == 4, "R6", sc_rises, 4);
    check(valid_wide == 0, "R8", valid_wide, 0);
    idle_check("R11", 1);

    // R2: half of 0 behaves as 1
    prep(1);
    half_i = 8'd0;
    words[0] = 10'h19C;
    mode_i = 2'd0;
    base = ncap;
    pulse_start();
    wait_cyc(40);
    check(duty_bad == 0 && n_rise == FR, "R2", duty_bad, 0);
    check(caps[base] == 10'h19C, "R7", caps[base], 10'h19C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule